// File: doc/BRIEF.md
# In-Order Dual-Issue Vector Queue

This block is a four-entry issue queue that sits between the dispatch stage and four vector execution sub-units. Each entry carries a small payload and a target tag that names one of the four sub-units. Each cycle dispatch may offer up to two instructions, and the queue appends them in age order behind the entries it already holds. It reports how many slots are free so that dispatch can throttle itself.

Each sub-unit drives a reservation-station-available flag. Only the two oldest entries can leave the queue, and they leave strictly in order. The oldest entry issues when its sub-unit has room. The second-oldest entry may issue with it in the same cycle if it targets a different sub-unit that also has room. Any two distinct sub-units may be paired in this way. Issued entries are removed, the survivors shift down, and the new arrivals are placed behind them, all in one clock edge. A flush input empties the queue.

Top module: `vec_issue_queue`

## Requirements
- R1: After reset the queue is empty: `free_slots` reads 4 and `iss_valid` reads 2'b00.
- R2: `iss_valid[0]` is 1 exactly when the queue holds at least one entry, `rs_avail[u]` is 1 for that entry's target code u, and `flush` is 0. When it is 1, `iss_unit0`/`iss_data0` show the oldest entry.
- R3: `iss_valid[1]` is 1 exactly when `iss_valid[0]` is 1, at least two entries are held, the second-oldest entry's target has `rs_avail` set, and its target differs from the oldest entry's target. When it is 1, `iss_unit1`/`iss_data1` show the second-oldest entry.
- R4: Entries older than the bottom two never issue. At most two entries leave per cycle, even when all four sub-units are available.
- R5: Dispatch slot 0 is older than slot 1. Slot 1 is considered only when slot 0 is valid, so `disp_valid` = 2'b10 is ignored. The number accepted is limited by the `free_slots` value shown in that cycle, and slot 1 is dropped first.
- R6: Issued entries are removed. The remaining entries keep their order, and accepted entries are appended behind them on the same edge, so entries issue in exactly the order they were accepted.
- R7: `free_slots` equals 4 minus the number of entries held at the start of the cycle. It does not depend on issue in that cycle.
- R8: While `flush` is 1, nothing issues and dispatch is ignored. On the following cycle the queue is empty.
- R9: Any ordered pair of distinct target codes (0..3) in the two oldest entries dual-issues when both sub-units are available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all held entries and this cycle's dispatch |
| disp_valid | input | 2 | Dispatch slot valids, bit 0 older |
| disp_unit0 | input | 2 | Target sub-unit of dispatch slot 0 |
| disp_data0 | input | 16 | Payload of dispatch slot 0 |
| disp_unit1 | input | 2 | Target sub-unit of dispatch slot 1 |
| disp_data1 | input | 16 | Payload of dispatch slot 1 |
| rs_avail | input | 4 | Reservation-station-available flag per sub-unit, indexed by target code |
| free_slots | output | 3 | Empty entries at the start of this cycle |
| iss_valid | output | 2 | Issue strobes, bit 0 for the oldest entry |
| iss_unit0 | output | 2 | Target of the oldest issuing entry |
| iss_data0 | output | 16 | Payload of the oldest issuing entry |
| iss_unit1 | output | 2 | Target of the second issuing entry |
| iss_data1 | output | 16 | Payload of the second issuing entry |

## Verification
The embedded properties assume that `rs_avail` and the dispatch inputs are stable during the cycle and known after reset. They make no assumption about dispatch honouring `free_slots`, because the queue clips any excess itself. The random stimulus draws every input from a seeded generator, including the ignored 2'b10 dispatch pattern, dispatch into a full queue, repeated targets and occasional flushes. It also holds `rs_avail` low for stretches so that the queue fills. Directed sequences then cover all twelve ordered target pairs and an overflow followed by a drain.

// File: rtl/vq_pkg.sv
package vq_pkg;
    parameter int VQ_DEPTH  = 4;
    parameter int NUM_UNITS = 4;
    parameter int DATA_W    = 16;
    parameter int ISSUE_W   = 2;

    localparam int UNIT_W = $clog2(NUM_UNITS);
    localparam int CNT_W  = $clog2(VQ_DEPTH + 1);
    localparam int NISS_W = $clog2(ISSUE_W + 1);

    typedef logic [UNIT_W-1:0] unit_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        unit_t             unit;
        logic [DATA_W-1:0] data;
    } vq_entry_t;

    function automatic logic can_pair(input unit_t a, input unit_t b);
        return a != b;
    endfunction
endpackage

// File: rtl/vq_issue_select.sv
module vq_issue_select
    import vq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  vq_entry_t             head0,
    input  vq_entry_t             head1,
    input  cnt_t                  occ,
    input  logic [NUM_UNITS-1:0]  rs_avail,
    output logic [1:0]            issue_mask,
    output logic [NISS_W-1:0]     n_issue
);
    logic ready0, ready1;

    always_comb begin
        ready0 = (occ >= cnt_t'(1)) && rs_avail[head0.unit];
        ready1 = (occ >= cnt_t'(2)) && rs_avail[head1.unit]
                 && can_pair(head0.unit, head1.unit);
        issue_mask[0] = !flush && ready0;
        issue_mask[1] = issue_mask[0] && ready1;
        n_issue = NISS_W'(issue_mask[0]) + NISS_W'(issue_mask[1]);
    end

    assert_inorder_R3: assert property (@(posedge clk) disable iff (rst)
        issue_mask[1] |-> issue_mask[0]);
    assert_rs_ready_R2: assert property (@(posedge clk) disable iff (rst)
        issue_mask[0] |-> rs_avail[head0.unit]);
    assert_distinct_R9: assert property (@(posedge clk) disable iff (rst)
        issue_mask[1] |-> (head0.unit != head1.unit) && rs_avail[head1.unit]);
    assert_held_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_mask[1] |-> occ >= cnt_t'(2)) and (issue_mask[0] |-> occ != '0));
    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> issue_mask == 2'b00);
endmodule

// File: rtl/vq_entry_store.sv
module vq_entry_store
    import vq_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic [1:0]                   disp_valid,
    input  vq_entry_t                    disp0,
    input  vq_entry_t                    disp1,
    input  logic [NISS_W-1:0]            n_issue,
    output vq_entry_t [VQ_DEPTH-1:0]     slots,
    output cnt_t                         occ,
    output cnt_t                         free
);
    vq_entry_t [VQ_DEPTH-1:0] slots_nxt;
    cnt_t keep, occ_nxt;
    logic acc0, acc1;

    always_comb begin
        free = cnt_t'(VQ_DEPTH) - occ;
        keep = occ - cnt_t'(n_issue);
        acc0 = disp_valid[0] && (free >= cnt_t'(1));
        acc1 = acc0 && disp_valid[1] && (free >= cnt_t'(2));
        occ_nxt = keep + cnt_t'(acc0) + cnt_t'(acc1);
    end

    for (genvar i = 0; i < VQ_DEPTH; i++) begin : g_slot
        localparam int SRC1 = (i + 1 < VQ_DEPTH) ? i + 1 : VQ_DEPTH - 1;
        localparam int SRC2 = (i + 2 < VQ_DEPTH) ? i + 2 : VQ_DEPTH - 1;
        always_comb begin
            if (cnt_t'(i) < keep) begin
                case (n_issue)
                    NISS_W'(1): slots_nxt[i] = slots[SRC1];
                    NISS_W'(2): slots_nxt[i] = slots[SRC2];
                    default:    slots_nxt[i] = slots[i];
                endcase
            end else if (acc0 && cnt_t'(i) == keep) begin
                slots_nxt[i] = disp0;
            end else if (acc1 && cnt_t'(i) == keep + cnt_t'(1)) begin
                slots_nxt[i] = disp1;
            end else begin
                slots_nxt[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            occ   <= '0;
            slots <= '0;
        end else begin
            occ   <= occ_nxt;
            slots <= slots_nxt;
        end
    end

    assert_occ_bound_R7: assert property (@(posedge clk) disable iff (rst)
        occ <= cnt_t'(VQ_DEPTH));
    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> occ == '0);
    assert_no_overfill_R5: assert property (@(posedge clk) disable iff (rst)
        !flush && free == '0 && n_issue == '0 |=> $stable(occ));
endmodule

// File: rtl/vec_issue_queue.sv
module vec_issue_queue
    import vq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic [1:0]           disp_valid,
    input  logic [UNIT_W-1:0]    disp_unit0,
    input  logic [DATA_W-1:0]    disp_data0,
    input  logic [UNIT_W-1:0]    disp_unit1,
    input  logic [DATA_W-1:0]    disp_data1,
    input  logic [NUM_UNITS-1:0] rs_avail,
    output logic [CNT_W-1:0]     free_slots,
    output logic [1:0]           iss_valid,
    output logic [UNIT_W-1:0]    iss_unit0,
    output logic [DATA_W-1:0]    iss_data0,
    output logic [UNIT_W-1:0]    iss_unit1,
    output logic [DATA_W-1:0]    iss_data1
);
    vq_entry_t [VQ_DEPTH-1:0] slots;
    vq_entry_t disp0, disp1;
    cnt_t occ, free;
    logic [1:0] issue_mask;
    logic [NISS_W-1:0] n_issue;

    assign disp0 = '{unit: disp_unit0, data: disp_data0};
    assign disp1 = '{unit: disp_unit1, data: disp_data1};

    vq_entry_store u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid), .disp0(disp0), .disp1(disp1),
        .n_issue(n_issue), .slots(slots), .occ(occ), .free(free)
    );

    vq_issue_select u_select (
        .clk(clk), .rst(rst), .flush(flush),
        .head0(slots[0]), .head1(slots[1]), .occ(occ),
        .rs_avail(rs_avail), .issue_mask(issue_mask), .n_issue(n_issue)
    );

    assign free_slots = free;
    assign iss_valid  = issue_mask;
    assign iss_unit0  = slots[0].unit;
    assign iss_data0  = slots[0].data;
    assign iss_unit1  = slots[1].unit;
    assign iss_data1  = slots[1].data;

    assert_drain_R6: assert property (@(posedge clk) disable iff (rst)
        !flush && disp_valid == 2'b00 && occ != '0 && iss_valid == 2'b01
        |=> occ == $past(occ) - cnt_t'(1));
endmodule

// File: tb/vec_issue_queue_test.sv
`timescale 1ns/1ps
module vec_issue_queue_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        flush = 0;
    logic [1:0]  disp_valid = 0;
    logic [1:0]  disp_unit0 = 0, disp_unit1 = 0;
    logic [15:0] disp_data0 = 0, disp_data1 = 0;
    logic [3:0]  rs_avail = 0;
    logic [2:0]  free_slots;
    logic [1:0]  iss_valid;
    logic [1:0]  iss_unit0, iss_unit1;
    logic [15:0] iss_data0, iss_data1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    int m_cnt = 0;
    int m_unit [4];
    int m_data [4];
    int tagctr = 1;

    vec_issue_queue uut (
        .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid),
        .disp_unit0(disp_unit0), .disp_data0(disp_data0),
        .disp_unit1(disp_unit1), .disp_data1(disp_data1),
        .rs_avail(rs_avail), .free_slots(free_slots), .iss_valid(iss_valid),
        .iss_unit0(iss_unit0), .iss_data0(iss_data0),
        .iss_unit1(iss_unit1), .iss_data1(iss_data1)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_iss0(input bit fl, input logic [3:0] rs);
        return (!fl && m_cnt >= 1 && rs[m_unit[0]]) ? 1 : 0;
    endfunction

    function automatic int exp_iss1(input bit fl, input logic [3:0] rs);
        return (exp_iss0(fl, rs) == 1 && m_cnt >= 2 && rs[m_unit[1]]
                && m_unit[1] != m_unit[0]) ? 1 : 0;
    endfunction

    task automatic step(input bit fl, input logic [1:0] dv,
                        input int u0, input int d0, input int u1, input int d1,
                        input logic [3:0] rs);
        int e0, e1, n, fr, acc;
        @(negedge clk);
        flush = fl; disp_valid = dv; rs_avail = rs;
        disp_unit0 = 2'(u0); disp_data0 = 16'(d0);
        disp_unit1 = 2'(u1); disp_data1 = 16'(d1);
        #1;
        e0 = exp_iss0(fl, rs);
        e1 = exp_iss1(fl, rs);
        fr = 4 - m_cnt;
        check("R7 free_slots", int'(free_slots), fr);
        check(fl ? "R8 iss_valid[0]" : "R2 iss_valid[0]", int'(iss_valid[0]), e0);
        check(fl ? "R8 iss_valid[1]" : "R3 iss_valid[1]", int'(iss_valid[1]), e1);
        if (e0 == 1) begin
            check("R6 iss_unit0", int'(iss_unit0), m_unit[0]);
            check("R6 iss_data0", int'(iss_data0), m_data[0]);
        end
        if (e1 == 1) begin
            check("R6 iss_unit1", int'(iss_unit1), m_unit[1]);
            check("R6 iss_data1", int'(iss_data1), m_data[1]);
        end
        if (fl) begin
            m_cnt = 0;
        end else begin
            n = e0 + e1;
            for (int i = 0; i < 4; i++)
                if (i + n < 4) begin
                    m_unit[i] = m_unit[i + n];
                    m_data[i] = m_data[i + n];
                end
            m_cnt -= n;
            acc = 0;
            if (dv[0] && fr >= 1) acc = 1;
            if (acc == 1 && dv[1] && fr >= 2) acc = 2;
            if (acc >= 1) begin m_unit[m_cnt] = u0; m_data[m_cnt] = d0; m_cnt++; end
            if (acc == 2) begin m_unit[m_cnt] = u1; m_data[m_cnt] = d1; m_cnt++; end
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R1 free_slots after reset", int'(free_slots), 4);
        check("R1 iss_valid after reset", int'(iss_valid), 0);

        // R9: all ordered distinct pairs dual-issue
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                if (a != b) begin
                    step(1, 2'b00, 0, 0, 0, 0, 4'h0);
                    step(0, 2'b11, a, 100 + a, b, 200 + b, 4'h0);
                    #2;
                    step(0, 2'b00, 0, 0, 0, 0, 4'hF);
                    check("R9 pair dual issue", int'(iss_valid), 3);
                end

        // R5: overflow and ignored slot-1-only dispatch, then R4 drain
        step(1, 2'b00, 0, 0, 0, 0, 4'h0);
        step(0, 2'b10, 3, 999, 3, 998, 4'h0);
        check("R5 2'b10 ignored", int'(free_slots), 4);
        step(0, 2'b11, 0, 11, 1, 12, 4'h0);
        step(0, 2'b11, 2, 13, 3, 14, 4'h0);
        step(0, 2'b11, 0, 15, 1, 16, 4'h0);
        check("R5 full queue drops dispatch", int'(free_slots), 0);
        step(0, 2'b00, 0, 0, 0, 0, 4'hF);
        check("R4 only two issue", int'(iss_valid), 3);
        step(0, 2'b00, 0, 0, 0, 0, 4'hF);
        check("R6 order after drain", int'(iss_data0), 13);
        // R3: same target pair issues singly
        step(1, 2'b00, 0, 0, 0, 0, 4'h0);
        step(0, 2'b11, 2, 21, 2, 22, 4'h0);
        step(0, 2'b00, 0, 0, 0, 0, 4'hF);
        check("R3 same unit single issue", int'(iss_valid), 1);

        // random phase
        for (int c = 0; c < 3000; c++) begin
            bit fl = ($urandom % 40) == 0;
            logic [3:0] rs = ((c / 64) % 3 == 0) ? 4'($urandom % 2) : 4'($urandom);
            step(fl, 2'($urandom), int'($urandom % 4), int'($urandom % 65536),
                 int'($urandom % 4), int'($urandom % 65536), rs);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule